// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Serial Port

This block is the digital serial side of a two-channel voice codec. Both channels share one bit clock, one serial transmit line and one serial receive line. Each channel has its own transmit sync input and its own receive sync input. A rising edge on a sync input opens an 8-bit time slot for that channel and direction. The block shifts a parallel companded byte out onto the shared tri-state transmit line, and it assembles a byte from the shared receive line for each channel.

Transmit bits change on the rising edge of the bit clock. Receive bits are sampled on the falling edge. A byte to transmit is first placed in a per-channel holding register through a valid/ready handshake. A received byte is presented per channel with a one-cycle valid strobe. Two transmit slots may ask for the line at overlapping times. The line then stays with the slot that opened first, and the late channel is flagged. The law-select pin and the two gain-select pins only pass through the block as registered status.

Top module: `pcm_slot_port`

## Requirements
- R1: While `rstN` is low at a rising edge (synchronous reset), the block clears everything on that edge. `txOe` goes low and no slot stays open. `txReady` reads 2'b11 and `rxValid` and `txCollide` read zero. `codeStat` reads 0 (µ-law) and `gainStat` reads 2'b11 (0 dB). This also holds when reset arrives in the middle of a slot.
- R2: A transmit slot opens at the first rising edge where a channel's `fsTx` bit is sampled high after being sampled low on the edge before. The most significant bit is on `txLine` right after that edge. Each following rising edge presents the next lower bit, so the 8 bits go out most significant first.
- R3: `txOe` is high for exactly the 8 clock cycles of a granted slot and low at all other times. Whenever `txOe` is low, `txLine` is high-impedance.
- R4: `txReady[c]` is high while the holding register of channel c is empty. A byte is taken when `txValid[c]` and `txReady[c]` are both high at a rising edge, and `txReady[c]` then drops. A granted slot takes the held byte and empties the register. A slot granted while the register is empty sends the idle byte 8'hFF.
- R5: A receive slot opens on a rising edge of `fsRx[c]`, detected the same way as in R2. Bit i of the slot (i = 0 for the most significant bit) is sampled from `rxData` on the falling edge that follows the i-th rising edge after the opening edge. `rxData` is ignored outside a channel's open receive slot.
- R6: `rxValid[c]` is high for exactly one cycle, right after the eighth rising edge that follows the opening edge. `rxWord[c]` then holds the assembled byte until the next slot of that channel completes.
- R7: A transmit sync edge that arrives while another slot holds the line is not granted. That channel gets a one-cycle `txCollide` pulse right after the edge where its sync was detected. The line keeps sending the slot already in progress, and the late channel's holding register keeps its byte.
- R8: If both channels show a transmit sync edge on the same rising edge, channel 0 gets the slot and channel 1 gets the collision pulse.
- R9: A sync edge detected on the same rising edge that ends a slot opens a new slot right away. `txOe` then stays high across both slots with no gap.
- R10: Sync is edge triggered. A sync input held high for many cycles opens only one slot and raises no collision.
- R11: `codeStat` follows `codingSel` (0 = µ-law, 1 = A-law) and `gainStat[c]` follows `gainSel[c]` (1 = 0 dB, 0 = -3.5 dB), each through one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; transmit on rising edge, receive on falling edge |
| rstN | input | 1 | Synchronous active-low reset |
| fsTx | input | 2 | Transmit sync, one bit per channel |
| fsRx | input | 2 | Receive sync, one bit per channel |
| txWord | input | 2x8 | Byte offered to each channel's holding register |
| txValid | input | 2 | Offer strobe per channel |
| txReady | output | 2 | Holding register empty per channel |
| rxData | input | 1 | Shared serial receive line |
| rxWord | output | 2x8 | Last byte received per channel |
| rxValid | output | 2 | One-cycle strobe for a new received byte |
| txLine | output | 1 | Shared serial transmit line, high-impedance when idle |
| txOe | output | 1 | High while a transmit slot drives `txLine` |
| txCollide | output | 2 | One-cycle pulse when a channel's transmit slot was refused |
| codingSel | input | 1 | Law select input (low µ-law, high A-law) |
| gainSel | input | 2 | Receive gain select per channel |
| codeStat | output | 1 | Registered law select |
| gainStat | output | 2 | Registered gain select per channel |

## Verification
The hardest cases to reach are the ones where a sync edge falls on a particular bit of a slot that is already running. One is a late sync in the middle of another channel's slot. The other is a sync on the very edge that ends a slot. The directed tasks reach them by counting rising edges from the opening sync and raising the second channel's sync while a known bit is on the line. Every bit position is checked on either side of the event, along with the collision pulse and the holding register that was kept. Level-held syncs and a reset in the middle of a slot are driven the same way, by bit count.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  parameter int CH_N   = 2;
  parameter int SLOT_W = 8;
  parameter int CNT_W  = $clog2(SLOT_W);
  parameter logic [SLOT_W-1:0] IDLE_WORD = '1;

  // strobes from control to datapath, one clock cycle each
  typedef struct packed {
    logic [CH_N-1:0] holdWr;   // capture txWord into holding register
    logic [CH_N-1:0] txLoad;   // granted channel: load shifter
    logic            txIdle;   // granted channel had nothing held
    logic            txShift;  // advance transmit shifter
    logic [CH_N-1:0] rxShift;  // shift captured bit into channel
    logic [CH_N-1:0] rxDone;   // eighth bit: publish byte
  } strobe_t;
endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_slot_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] fsTx,
  input  logic [CH_N-1:0] fsRx,
  input  logic [CH_N-1:0] txValid,
  output logic [CH_N-1:0] txReady,
  output logic            txDrive,
  output logic [CH_N-1:0] txCollide,
  output strobe_t         strb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_W - 1);

  logic [CH_N-1:0] fsTxPrev, fsRxPrev, holdFull;
  logic [CH_N-1:0] txEdge, rxEdge, grant, collideNext, accept;
  logic [CH_N-1:0] rxBusyV, rxLastV;
  logic            txBusy, txLast, lineFree, granted;
  logic [CNT_W-1:0] txCnt;

  assign txEdge   = fsTx & ~fsTxPrev;
  assign rxEdge   = fsRx & ~fsRxPrev;
  assign txLast   = txBusy && (txCnt == LAST_BIT);
  assign lineFree = !txBusy || txLast;
  assign accept   = txValid & ~holdFull;

  // lowest index wins when several edges meet a free line
  always_comb begin
    grant   = '0;
    granted = 1'b0;
    for (int c = 0; c < CH_N; c++) begin
      if (txEdge[c] && lineFree && !granted) begin
        grant[c] = 1'b1;
        granted  = 1'b1;
      end
    end
  end

  assign collideNext = txEdge & ~grant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsTxPrev  <= '0;
      fsRxPrev  <= '0;
      holdFull  <= '0;
      txBusy    <= 1'b0;
      txCnt     <= '0;
      txCollide <= '0;
    end else begin
      fsTxPrev  <= fsTx;
      fsRxPrev  <= fsRx;
      txCollide <= collideNext;
      holdFull  <= (holdFull & ~grant) | accept;
      txBusy    <= granted | (txBusy & ~txLast);
      if (granted)     txCnt <= '0;
      else if (txBusy) txCnt <= txCnt + 1'b1;
    end
  end

  // independent receive slot sequencers
  for (genvar c = 0; c < CH_N; c++) begin : g_rx
    logic             busyQ;
    logic [CNT_W-1:0] cntQ;
    logic             lastC, startC;
    assign lastC  = busyQ && (cntQ == LAST_BIT);
    assign startC = rxEdge[c] && (!busyQ || lastC);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        busyQ <= startC | (busyQ & ~lastC);
        if (startC)     cntQ <= '0;
        else if (busyQ) cntQ <= cntQ + 1'b1;
      end
    end
    assign rxBusyV[c] = busyQ;
    assign rxLastV[c] = lastC;
  end

  assign txReady      = ~holdFull;
  assign txDrive      = txBusy;
  assign strb.holdWr  = accept;
  assign strb.txLoad  = grant;
  assign strb.txIdle  = ~|(grant & holdFull);
  assign strb.txShift = txBusy;
  assign strb.rxShift = rxBusyV;
  assign strb.rxDone  = rxLastV;
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_slot_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [CH_N-1:0][SLOT_W-1:0]  txWord,
  input  logic                         rxData,
  input  logic                         codingSel,
  input  logic [CH_N-1:0]              gainSel,
  output logic                         txBit,
  output logic [CH_N-1:0][SLOT_W-1:0]  rxWord,
  output logic [CH_N-1:0]              rxValid,
  output logic                         codeStat,
  output logic [CH_N-1:0]              gainStat
);
  logic [CH_N-1:0][SLOT_W-1:0] hold;
  logic [CH_N-1:0][SLOT_W-1:0] rxSh;
  logic [SLOT_W-1:0]           txSh, loadVal;
  logic                        rxBitQ;

  always_comb begin
    loadVal = IDLE_WORD;
    for (int c = 0; c < CH_N; c++) begin
      if (strb.txLoad[c] && !strb.txIdle) loadVal = hold[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh     <= '0;
      codeStat <= 1'b0;
      gainStat <= '1;
    end else begin
      codeStat <= codingSel;
      gainStat <= gainSel;
      if (|strb.txLoad)     txSh <= loadVal;
      else if (strb.txShift) txSh <= {txSh[SLOT_W-2:0], 1'b0};
    end
  end

  assign txBit = txSh[SLOT_W-1];

  // receive line sampled on the falling edge
  always_ff @(negedge clk) begin
    if (!rstN) rxBitQ <= 1'b0;
    else       rxBitQ <= rxData;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (strb.holdWr[c]) hold[c] <= txWord[c];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxSh[c]    <= '0;
        rxWord[c]  <= '0;
        rxValid[c] <= 1'b0;
      end else begin
        rxValid[c] <= strb.rxDone[c];
        if (strb.rxShift[c]) rxSh[c]   <= {rxSh[c][SLOT_W-2:0], rxBitQ};
        if (strb.rxDone[c])  rxWord[c] <= {rxSh[c][SLOT_W-2:0], rxBitQ};
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
(
  input  logic                         bitClk,
  input  logic                         rstN,
  input  logic [CH_N-1:0]              fsTx,
  input  logic [CH_N-1:0]              fsRx,
  input  logic [CH_N-1:0][SLOT_W-1:0]  txWord,
  input  logic [CH_N-1:0]              txValid,
  output logic [CH_N-1:0]              txReady,
  input  logic                         rxData,
  output logic [CH_N-1:0][SLOT_W-1:0]  rxWord,
  output logic [CH_N-1:0]              rxValid,
  output wire                          txLine,
  output logic                         txOe,
  output logic [CH_N-1:0]              txCollide,
  input  logic                         codingSel,
  input  logic [CH_N-1:0]              gainSel,
  output logic                         codeStat,
  output logic [CH_N-1:0]              gainStat
);
  strobe_t strb;
  logic    txBit;

  pcm_port_ctrl u_ctrl (
    .clk       (bitClk),
    .rstN      (rstN),
    .fsTx      (fsTx),
    .fsRx      (fsRx),
    .txValid   (txValid),
    .txReady   (txReady),
    .txDrive   (txOe),
    .txCollide (txCollide),
    .strb      (strb)
  );

  pcm_port_datapath u_dp (
    .clk       (bitClk),
    .rstN      (rstN),
    .strb      (strb),
    .txWord    (txWord),
    .rxData    (rxData),
    .codingSel (codingSel),
    .gainSel   (gainSel),
    .txBit     (txBit),
    .rxWord    (rxWord),
    .rxValid   (rxValid),
    .codeStat  (codeStat),
    .gainStat  (gainStat)
  );

  assign txLine = txOe ? txBit : 1'bz;
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk
  import pcm_slot_pkg::*;
(
  input logic            bitClk,
  input logic            rstN,
  input logic [CH_N-1:0] fsTx,
  input logic [CH_N-1:0] txValid,
  input logic [CH_N-1:0] txReady,
  input logic [CH_N-1:0] rxValid,
  input logic            txOe,
  input logic [CH_N-1:0] txCollide,
  input logic            codingSel,
  input logic [CH_N-1:0] gainSel,
  input logic            codeStat,
  input logic [CH_N-1:0] gainStat
);
  AST_OE_NEEDS_SYNC_EDGE: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(txOe) |-> ((|($past(fsTx) & ~$past(fsTx, 2))) || !$past(rstN, 2))); // R2

  AST_CODE_FOLLOWS: assert property (@(posedge bitClk) disable iff (!rstN)
    $past(rstN) |-> (codeStat == $past(codingSel))); // R11

  AST_GAIN_FOLLOWS: assert property (@(posedge bitClk) disable iff (!rstN)
    $past(rstN) |-> (gainStat == $past(gainSel))); // R11

  for (genvar c = 0; c < CH_N; c++) begin : g_c
    AST_READY_DROPS: assert property (@(posedge bitClk) disable iff (!rstN)
      (txValid[c] && txReady[c]) |=> !txReady[c]); // R4

    AST_RXVALID_SINGLE: assert property (@(posedge bitClk) disable iff (!rstN)
      rxValid[c] |=> !rxValid[c]); // R6

    AST_COLLIDE_CAUSE: assert property (@(posedge bitClk) disable iff (!rstN)
      txCollide[c] |-> ($past(fsTx[c]) && (!$past(fsTx[c], 2) || !$past(rstN, 2)))); // R7
  end
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (.*);

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;
  localparam int CLK_PERIOD = 10;

  logic            bitClk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      fsTx = '0, fsRx = '0, txValid = '0, gainSel = 2'b11;
  logic [1:0][7:0] txWord = '0;
  logic            rxData = 1'b0, codingSel = 1'b0;
  logic [1:0]      txReady, rxValid, txCollide, gainStat;
  logic [1:0][7:0] rxWord;
  logic            txOe, codeStat;
  wire             txLine;

  int vecCnt = 0;
  int errCnt = 0;

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  pcm_slot_port u0 (
    .bitClk(bitClk), .rstN(rstN), .fsTx(fsTx), .fsRx(fsRx),
    .txWord(txWord), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxWord(rxWord), .rxValid(rxValid),
    .txLine(txLine), .txOe(txOe), .txCollide(txCollide),
    .codingSel(codingSel), .gainSel(gainSel),
    .codeStat(codeStat), .gainStat(gainStat)
  );

  task automatic tick();
    @(posedge bitClk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadTx(input int ch, input logic [7:0] w);
    chk("R4 ready before load", int'(txReady[ch]), 1);
    txWord[ch] = w;
    txValid[ch] = 1'b1;
    tick();
    txValid[ch] = 1'b0;
    chk("R4 ready after load", int'(txReady[ch]), 0);
  endtask

  // called just after edge k-1; checks the slot opening at edge k
  task automatic sendSlot(input int ch, input logic [7:0] w, input string req);
    fsTx[ch] = 1'b1;
    tick();
    fsTx[ch] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk({req, " oe"}, int'(txOe), 1);
      chk({req, " bit"}, int'(txLine), int'(w[7-i]));
      tick();
    end
    chk({req, " oe after"}, int'(txOe), 0);
  endtask

  task automatic recvSlot(input int ch, input logic [7:0] w);
    logic [7:0] other;
    other = rxWord[1-ch];
    fsRx[ch] = 1'b1;
    tick();
    fsRx[ch] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rxData = w[7-i];
      chk("R6 no early valid", int'(rxValid), 0);
      tick();
    end
    chk("R6 valid pulse", int'(rxValid), 1 << ch);
    chk("R5 word", int'(rxWord[ch]), int'(w));
    chk("R5 other channel untouched", int'(rxWord[1-ch]), int'(other));
    rxData = 1'b1;
    tick();
    chk("R6 valid one cycle", int'(rxValid), 0);
    chk("R6 word held", int'(rxWord[ch]), int'(w));
  endtask

  task automatic testReset();
    codingSel = 1'b1;
    gainSel = 2'b00;
    tick();
    tick();
    chk("R1 oe", int'(txOe), 0);
    chk("R1 ready", int'(txReady), 3);
    chk("R1 rxValid", int'(rxValid), 0);
    chk("R1 collide", int'(txCollide), 0);
    chk("R1 code", int'(codeStat), 0);
    chk("R1 gain", int'(gainStat), 3);
    codingSel = 1'b0;
    gainSel = 2'b11;
    rstN = 1'b1;
    tick();
  endtask

  task automatic testTxBasic();
    tick();
    chk("R3 idle oe", int'(txOe), 0);
    loadTx(0, 8'hA5);
    sendSlot(0, 8'hA5, "R2");
    chk("R4 consumed", int'(txReady[0]), 1);
  endtask

  task automatic testTxIdle();
    sendSlot(1, 8'hFF, "R4 idle");
  endtask

  task automatic testRx();
    rxData = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk("R5 ignored outside slot", int'(rxValid), 0);
    chk("R5 ignored word", int'(rxWord[1]), 0);
    recvSlot(1, 8'h3C);
    recvSlot(0, 8'h96);
  endtask

  task automatic testCollide();
    loadTx(0, 8'h11);
    loadTx(1, 8'h22);
    fsTx[0] = 1'b1;
    tick();
    fsTx[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R7 oe", int'(txOe), 1);
      chk("R7 line kept", int'(txLine), int'(8'h11 >> (7-i)) & 1);
      if (i == 2) fsTx[1] = 1'b1;
      if (i == 3) begin
        chk("R7 collide pulse", int'(txCollide), 2);
        fsTx[1] = 1'b0;
      end
      if (i == 4) chk("R7 collide ends", int'(txCollide), 0);
      tick();
    end
    chk("R7 oe end", int'(txOe), 0);
    chk("R7 hold kept", int'(txReady[1]), 0);
    sendSlot(1, 8'h22, "R7 retained");
  endtask

  task automatic testSimul();
    loadTx(0, 8'h5A);
    loadTx(1, 8'hC3);
    fsTx = 2'b11;
    tick();
    fsTx = 2'b00;
    chk("R8 ch1 refused", int'(txCollide), 2);
    for (int i = 0; i < 8; i++) begin
      chk("R8 ch0 bit", int'(txLine), int'(8'h5A >> (7-i)) & 1);
      tick();
    end
    chk("R8 ch1 hold kept", int'(txReady[1]), 0);
  endtask

  task automatic testBackToBack();
    loadTx(0, 8'h0F);
    fsTx[1] = 1'b1;
    tick();
    fsTx[1] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R9 first slot bit", int'(txLine), int'(8'hC3 >> (7-i)) & 1);
      if (i == 7) fsTx[0] = 1'b1;
      tick();
    end
    fsTx[0] = 1'b0;
    chk("R9 no collide", int'(txCollide), 0);
    for (int i = 0; i < 8; i++) begin
      chk("R9 oe continuous", int'(txOe), 1);
      chk("R9 second slot bit", int'(txLine), int'(8'h0F >> (7-i)) & 1);
      tick();
    end
    chk("R9 oe end", int'(txOe), 0);
  endtask

  task automatic testLevel();
    fsTx[0] = 1'b1;
    tick();
    for (int i = 0; i < 8; i++) begin
      chk("R10 bit", int'(txLine), 1);
      tick();
    end
    for (int i = 0; i < 4; i++) begin
      chk("R10 no reopen", int'(txOe), 0);
      chk("R10 no collide", int'(txCollide), 0);
      tick();
    end
    fsTx[0] = 1'b0;
    tick();
  endtask

  task automatic testStatus();
    codingSel = 1'b1;
    gainSel = 2'b01;
    chk("R11 code before edge", int'(codeStat), 0);
    tick();
    chk("R11 code A-law", int'(codeStat), 1);
    chk("R11 gain", int'(gainStat), 1);
    gainSel = 2'b10;
    tick();
    chk("R11 gain swap", int'(gainStat), 2);
  endtask

  task automatic testResetMid();
    loadTx(0, 8'h77);
    fsTx[0] = 1'b1;
    tick();
    fsTx[0] = 1'b0;
    tick();
    tick();
    chk("R1 slot running", int'(txOe), 1);
    rstN = 1'b0;
    tick();
    chk("R1 mid-slot oe", int'(txOe), 0);
    chk("R1 mid-slot ready", int'(txReady), 3);
    chk("R1 mid-slot status", int'(codeStat), 0);
    rstN = 1'b1;
    tick();
    chk("R1 stays idle", int'(txOe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errCnt++;
    vecCnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    testReset();
    testTxBasic();
    testTxIdle();
    testRx();
    testCollide();
    testSimul();
    testBackToBack();
    testLevel();
    testStatus();
    testResetMid();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule